// File: doc/BRIEF.md
# Quarter-Duty Half-Bias Segment LCD Driver

This block drives a multiplexed segment display with four common lines and twenty segment lines. A small memory holds four bits per segment pin, one for each common. The block walks through four common time slots in turn and emits a 2-bit drive-level code on every pin. An external resistor ladder or analog stage turns each code into ground, half supply or full supply. Drive polarity flips on every other frame, so each pixel sees no net DC.

Segment data enters through a valid/ready write port. A word is taken on a rising edge where both `wr_valid` and `wr_ready` are high. `wr_ready` is low during reset, on the first cycle after reset and in backup. A source must hold its word until it is taken. Words are buffered in the memory, and the display picks them up at the next slot boundary, so a burst of writes never tears a slot.

Two groups of four segment pins can be handed over to general-purpose use. Backup mode parks the display: common and segment outputs go low, pins handed over to general-purpose use are released, and the slot timer stops.

Top module: `lcd_quad_drv`

## Requirements
- R1: During reset and after it, every common and segment output carries code 00 (low) until the first slot boundary. That boundary is the rising edge on which the slot counter completes `SLOT_CLKS` (default 250) counted clocks. After reset both shared groups are in segment mode.
- R2: Each common slot lasts `SLOT_CLKS` counted clocks. Slots run 0, 1, 2, 3 and then repeat, so one frame is four slots.
- R3: Levels are coded 00 low, 01 mid and 10 high. During slot s, common s carries 10 on a normal frame and 00 on an inverted frame, and the other three commons carry 01.
- R4: The first frame after reset is normal. Polarity toggles each time slot 0 begins.
- R5: Bit s of a segment's word selects the segment's level during slot s. When the bit is 1, the segment carries the level opposite the selected common (00 on normal frames, 10 on inverted frames). When the bit is 0, it carries the same level as the selected common.
- R6: A write stores `wr_bits` for segment `wr_idx`. The data is shown from the first slot boundary strictly after the accepting edge, and not before. `wr_ready` is high out of reset when backup is low.
- R7: A write whose index is 20 or more changes no segment.
- R8: While `backup` is high, all commons and all segment-mode pins carry 00 in the same cycle, `wr_ready` is low and the slot timer does not advance. On exit, timing resumes from where it stopped.
- R9: A `cfg_we` pulse loads `cfg_gpio`. Bit g = 1 hands segments 12+4g to 15+4g (shared pins 4g..4g+3) to general-purpose use. A handed-over pin carries 10 or 00 from `gp_out` when its `gp_oe` is 1, and otherwise 11 (released) with its `gp_in_en` high. A pin in segment mode never carries 11.
- R10: In backup, handed-over pins carry 11 and their `gp_in_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 75 kHz timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| backup | input | 1 | Backup mode: outputs parked, timer frozen |
| wr_valid | input | 1 | Segment write request |
| wr_ready | output | 1 | Write port can take a word |
| wr_idx | input | 5 | Segment index of the write |
| wr_bits | input | 4 | Per-common bits, bit s for slot s |
| cfg_we | input | 1 | Load group handover bits |
| cfg_gpio | input | 2 | Group handover bits, 1 = general-purpose |
| gp_out | input | 8 | General-purpose output value per shared pin |
| gp_oe | input | 8 | General-purpose output enable per shared pin |
| com_lvl | output | 8 | Common level codes, 2 bits per common |
| seg_lvl | output | 40 | Segment level codes, 2 bits per segment |
| gp_in_en | output | 8 | Input enable per shared pin |

## Verification
Output codes are decoded directly from registers, so every result can be counted in edges. A taken write reaches the screen on the boundary edge that follows it. The first boundary is the 250th counted rising edge after reset, and each later one comes 250 counted edges after the previous. `backup`, `gp_out` and `gp_oe` act in the same cycle with no edge, while `cfg_we` takes effect on its own edge. The bench keeps its own edge counter, which stalls while backup is high. It snapshots its model memory on the edges where a boundary falls, samples after falling edges, and never writes on a boundary edge except where the deferral itself is under test.

// File: rtl/lcdq_pkg.sv
package lcdq_pkg;
  typedef enum logic [1:0] {
    LV_LOW  = 2'b00,
    LV_MID  = 2'b01,
    LV_HIGH = 2'b10,
    LV_REL  = 2'b11
  } lvl_e;
  localparam int NCOM = 4;
endpackage

// File: rtl/lcdq_timebase.sv
module lcdq_timebase #(
  parameter int SLOT_CLKS = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  output logic [1:0] slot,
  output logic       inv,
  output logic       run,
  output logic       bnd
);
  localparam int CNT_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign bnd = !hold && (cnt_q == LAST);

  // slot 3 / inverted at reset so the first boundary enters slot 0 of a normal frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      slot  <= 2'd3;
      inv   <= 1'b1;
      run   <= 1'b0;
    end else if (!hold) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        slot  <= slot + 2'd1;
        if (slot == 2'd3) inv <= ~inv;
        run   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot != $past(slot)) |-> ($past(cnt_q) == LAST && !$past(hold)));

  // R4
  inv_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inv != $past(inv)) |-> (slot == 2'd0));

  // R8
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == $past(cnt_q) && slot == $past(slot)));
endmodule

// File: rtl/lcdq_segram.sv
module lcdq_segram #(
  parameter int NUM_SEG = 20,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [3:0]         wbits,
  input  logic               bnd,
  input  logic [1:0]         nslot,
  output logic [NUM_SEG-1:0] col
);
  logic [3:0] mem_q [NUM_SEG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SEG; i++) mem_q[i] <= '0;
      col <= '0;
    end else begin
      for (int i = 0; i < NUM_SEG; i++)
        if (we && widx == IDX_W'(i)) mem_q[i] <= wbits;
      if (bnd)
        for (int i = 0; i < NUM_SEG; i++) col[i] <= mem_q[i][nslot];
    end
  end

  // R6
  col_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col != $past(col)) |-> $past(bnd));
endmodule

// File: rtl/lcdq_encode.sv
module lcdq_encode
  import lcdq_pkg::*;
#(
  parameter int NUM_SEG = 20
) (
  input  logic [1:0]           slot,
  input  logic                 inv,
  input  logic                 run,
  input  logic [NUM_SEG-1:0]   col,
  output logic [2*NCOM-1:0]    com_code,
  output logic [2*NUM_SEG-1:0] seg_code
);
  logic [1:0] same_lv, opp_lv;

  always_comb begin
    same_lv = inv ? LV_LOW : LV_HIGH;
    opp_lv  = inv ? LV_HIGH : LV_LOW;
    for (int c = 0; c < NCOM; c++) begin
      if (!run)                com_code[2*c +: 2] = LV_LOW;
      else if (slot == 2'(c))  com_code[2*c +: 2] = same_lv;
      else                     com_code[2*c +: 2] = LV_MID;
    end
    for (int i = 0; i < NUM_SEG; i++) begin
      if (!run)        seg_code[2*i +: 2] = LV_LOW;
      else if (col[i]) seg_code[2*i +: 2] = opp_lv;
      else             seg_code[2*i +: 2] = same_lv;
    end
  end
endmodule

// File: rtl/lcd_quad_drv.sv
module lcd_quad_drv
  import lcdq_pkg::*;
#(
  parameter int NUM_SEG   = 20,
  parameter int SLOT_CLKS = 250,
  parameter int NUM_GRP   = 2,
  parameter int GRP_BASE  = 12,
  localparam int NSH   = 4 * NUM_GRP,
  localparam int IDX_W = $clog2(NUM_SEG)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 backup,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [3:0]           wr_bits,
  input  logic                 cfg_we,
  input  logic [NUM_GRP-1:0]   cfg_gpio,
  input  logic [NSH-1:0]       gp_out,
  input  logic [NSH-1:0]       gp_oe,
  output logic [2*NCOM-1:0]    com_lvl,
  output logic [2*NUM_SEG-1:0] seg_lvl,
  output logic [NSH-1:0]       gp_in_en
);
  logic [1:0]           slot;
  logic                 inv, run, bnd;
  logic [NUM_SEG-1:0]   col;
  logic [2*NCOM-1:0]    enc_com;
  logic [2*NUM_SEG-1:0] enc_seg;
  logic [NUM_GRP-1:0]   grp_q;
  logic                 awake_q;
  logic [NUM_SEG-1:0]   seg_rel, seg_mode;
  logic [NCOM-1:0]      com_nonmid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q   <= '0;
      awake_q <= 1'b0;
    end else begin
      awake_q <= 1'b1;
      if (cfg_we) grp_q <= cfg_gpio;
    end
  end

  assign wr_ready = awake_q && !backup;

  lcdq_timebase #(.SLOT_CLKS(SLOT_CLKS)) tb_i (
    .clk(clk), .rst_n(rst_n), .hold(backup),
    .slot(slot), .inv(inv), .run(run), .bnd(bnd)
  );

  lcdq_segram #(.NUM_SEG(NUM_SEG)) ram_i (
    .clk(clk), .rst_n(rst_n), .we(wr_valid && wr_ready),
    .widx(wr_idx), .wbits(wr_bits), .bnd(bnd),
    .nslot(slot + 2'd1), .col(col)
  );

  lcdq_encode #(.NUM_SEG(NUM_SEG)) enc_i (
    .slot(slot), .inv(inv), .run(run), .col(col),
    .com_code(enc_com), .seg_code(enc_seg)
  );

  assign com_lvl = backup ? '0 : enc_com;

  for (genvar c = 0; c < NCOM; c++) begin : g_com
    assign com_nonmid[c] = (com_lvl[2*c +: 2] != LV_MID);
  end

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    if (i >= GRP_BASE && i < GRP_BASE + NSH) begin : g_shared
      localparam int J = i - GRP_BASE;
      localparam int G = J / 4;
      always_comb begin
        if (grp_q[G])
          seg_lvl[2*i +: 2] = (backup || !gp_oe[J]) ? LV_REL
                            : (gp_out[J] ? LV_HIGH : LV_LOW);
        else
          seg_lvl[2*i +: 2] = backup ? LV_LOW : enc_seg[2*i +: 2];
      end
      assign gp_in_en[J] = grp_q[G] && !gp_oe[J] && !backup;
      assign seg_mode[i] = !grp_q[G];
    end else begin : g_plain
      assign seg_lvl[2*i +: 2] = backup ? LV_LOW : enc_seg[2*i +: 2];
      assign seg_mode[i] = 1'b1;
    end
    assign seg_rel[i] = (seg_lvl[2*i +: 2] == LV_REL);
  end

  // R3
  one_common_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !backup) |-> ($countones(com_nonmid) == 1));

  // R9
  seg_mode_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_rel & seg_mode) == '0);

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (com_lvl == '0));
endmodule

// File: tb/lcd_quad_drv_tb_top.sv
module lcd_quad_drv_tb_top;
  localparam int NSEG  = 20;
  localparam int SLOT  = 250;
  localparam int GBASE = 12;
  localparam int NSH   = 8;

  logic clk = 1'b0, rst_n = 1'b0, backup = 1'b0, wr_valid = 1'b0, cfg_we = 1'b0;
  logic [4:0] wr_idx = '0;
  logic [3:0] wr_bits = '0;
  logic [1:0] cfg_gpio = '0;
  logic [NSH-1:0] gp_out = '0, gp_oe = '0;
  logic wr_ready;
  logic [7:0] com_lvl;
  logic [2*NSEG-1:0] seg_lvl;
  logic [NSH-1:0] gp_in_en;

  int ecnt = 0, n_chk = 0, n_fail = 0;
  logic [3:0] mem_m [NSEG];
  logic [3:0] shown [NSEG];
  logic [1:0] grp_m = '0;

  lcd_quad_drv dut_i (
    .clk(clk), .rst_n(rst_n), .backup(backup), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_idx(wr_idx), .wr_bits(wr_bits), .cfg_we(cfg_we),
    .cfg_gpio(cfg_gpio), .gp_out(gp_out), .gp_oe(gp_oe), .com_lvl(com_lvl),
    .seg_lvl(seg_lvl), .gp_in_en(gp_in_en)
  );

  always #10 clk = ~clk;

  // bench edge count and slot-boundary snapshot of the model memory
  always @(posedge clk) begin
    if (rst_n && !backup) begin
      ecnt <= ecnt + 1;
      if (ecnt + 1 >= SLOT && ((ecnt + 1 - SLOT) % SLOT) == 0)
        for (int i = 0; i < NSEG; i++) shown[i] <= mem_m[i];
    end
  end

  function automatic logic [1:0] e_com(int c);
    int k, sl;
    bit pv;
    if (backup || ecnt < SLOT) return 2'b00;
    k = (ecnt - SLOT) / SLOT; sl = k % 4; pv = ((k / 4) % 2) == 1;
    if (c != sl) return 2'b01;
    return pv ? 2'b00 : 2'b10;
  endfunction

  function automatic logic [1:0] e_seg(int i);
    int k, sl, j;
    bit pv;
    if (i >= GBASE && i < GBASE + NSH) begin
      j = i - GBASE;
      if (grp_m[j / 4]) return (backup || !gp_oe[j]) ? 2'b11 : (gp_out[j] ? 2'b10 : 2'b00);
    end
    if (backup || ecnt < SLOT) return 2'b00;
    k = (ecnt - SLOT) / SLOT; sl = k % 4; pv = ((k / 4) % 2) == 1;
    if (shown[i][sl]) return pv ? 2'b10 : 2'b00;
    return pv ? 2'b00 : 2'b10;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    #1;
    for (int c = 0; c < 4; c++)
      chk(com_lvl[2*c +: 2] == e_com(c), $sformatf("R3 %s com%0d", ctx, c),
          com_lvl[2*c +: 2], e_com(c));
    for (int i = 0; i < NSEG; i++)
      chk(seg_lvl[2*i +: 2] == e_seg(i), $sformatf("R5 %s seg%0d", ctx, i),
          seg_lvl[2*i +: 2], e_seg(i));
    for (int j = 0; j < NSH; j++) begin
      bit ie;
      ie = grp_m[j / 4] && !gp_oe[j] && !backup;
      chk(gp_in_en[j] == ie, $sformatf("R9 %s in_en%0d", ctx, j), gp_in_en[j], ie);
    end
  endtask

  task automatic wait_to(int e);
    while (ecnt < e) @(negedge clk);
  endtask

  task automatic wr(int idx, logic [3:0] b, bit take);
    wr_idx = 5'(idx); wr_bits = b; wr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    if (take && idx < NSEG) mem_m[idx] = b;
  endtask

  task automatic cfg(logic [1:0] v);
    cfg_gpio = v; cfg_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; grp_m = v;
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int b0;
    for (int i = 0; i < NSEG; i++) begin mem_m[i] = '0; shown[i] = '0; end
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    check_all("R1 after reset");
    @(negedge clk);
    chk(wr_ready == 1'b1, "R6 ready after reset", wr_ready, 1);
    for (int i = 0; i < NSEG; i++) wr(i, 4'(i * 5 + 1), 1'b1);
    wait_to(120); check_all("R1 idle");
    wait_to(SLOT - 1); check_all("R1 last idle");
    for (int k = 0; k < 8; k++) begin
      b0 = SLOT + SLOT * k;
      wait_to(b0);            check_all($sformatf("R2 start %0d", k));
      wait_to(b0 + 125);      check_all($sformatf("R4 mid %0d", k));
      wait_to(b0 + SLOT - 1); check_all($sformatf("R2 end %0d", k));
    end
    // R6: deferral to the next boundary
    wait_to(2300);
    wr(3, ~mem_m[3], 1'b1);  check_all("R6 just written");
    wait_to(2499);           check_all("R6 still old");
    wait_to(2500);           check_all("R6 now shown");
    // R7: out-of-range indices
    wr(20, 4'hF, 1'b1);
    wr(31, 4'hA, 1'b1);
    wait_to(2750);           check_all("R7 out of range");
    // R9: group handover
    gp_oe = 8'b0101_0000; gp_out = 8'b0011_0000;
    cfg(2'b10);              check_all("R9 group1");
    gp_oe = 8'b0000_1101; gp_out = 8'b0000_0101;
    cfg(2'b11);              check_all("R9 both");
    wait_to(2900);           check_all("R9 both later");
    // R8 / R10: backup
    backup = 1'b1;           check_all("R8 R10 backup");
    chk(wr_ready == 1'b0, "R8 ready in backup", wr_ready, 0);
    wr(0, ~mem_m[0], 1'b0);
    repeat (100) @(negedge clk);
    check_all("R8 R10 held");
    backup = 1'b0;           check_all("R8 resume");
    wait_to(3000);           check_all("R8 write refused");
    cfg(2'b00);              check_all("R9 restored");
    for (int i = 0; i < NSEG; i++) wr(i, 4'(i * 3 + 7), 1'b1);
    b0 = ecnt;
    for (int e = b0 + 1; e < b0 + 2400; e += 37) begin
      wait_to(e); check_all("R2 sweep");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule